// File: doc/BRIEF.md
# Wide Bus Chained Byte Assembler

This block turns a stream of bytes into 16-bit words for a wide parallel data bus. Each byte arrives with a valid/ready handshake, a block-end marker and a direction bit that says whether the block is being sent or received. In wide mode, consecutive bytes are paired into a word, with the earlier byte in the low half. In narrow mode, every byte becomes its own word.

A wide block may end with an odd number of bytes. The final byte is then not padded. It is parked in a holding register kept for that direction, and a residue flag for that direction goes high. The first byte of the next block in the same direction completes the word, with the parked byte in the low half.

Software can discard a parked byte by pulsing a clear strobe. The send residue is also dropped by any receive transfer and by any narrow transfer.

Top module: `byte_pair_packer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid_o`, `tx_resid_o` and `rx_resid_o` are 0 and `in_ready_o` is 1.
- R2: In wide mode (`in_wide_i`=1), every two accepted bytes of one direction produce one word. The earlier byte sits in bits [7:0] and the later byte in bits [15:8]. The word becomes visible on `out_valid_o`/`out_data_o` in the cycle after the second byte is accepted.
- R3: A wide send block (`in_dir_i`=0) that ends on an odd byte produces no word for its last byte. From the cycle after that byte is accepted, `tx_resid_o` reads 1.
- R4: While `tx_resid_o` is 1, the first byte of the next wide send block yields the word {new byte, parked byte}, and `tx_resid_o` returns to 0.
- R5: Receive blocks (`in_dir_i`=1) behave the same way but use a separate holding register and `rx_resid_o`. A receive residue is paired only with the next receive byte.
- R6: A one-cycle pulse on `tx_clr_i` (or `rx_clr_i`) makes the matching flag read 0 on the next cycle and discards the parked byte. A wide byte of the same direction accepted in the same cycle as the pulse starts a fresh, even pairing.
- R7: Accepting any receive byte makes `tx_resid_o` read 0 on the next cycle.
- R8: A byte accepted in narrow mode (`in_wide_i`=0) produces the word {8'h00, byte} on the next cycle and makes `tx_resid_o` read 0. It leaves `rx_resid_o` unchanged.
- R9: Once `out_valid_o` is 1, it stays 1 with `out_data_o` unchanged until a cycle in which `out_ready_i` is 1. `in_ready_o` is 0 exactly when `out_valid_o` is 1 and `out_ready_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte ready |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Byte is the last of its block |
| in_dir_i | input | 1 | 0 = send, 1 = receive |
| in_wide_i | input | 1 | 1 = wide (paired) transfer, 0 = narrow |
| tx_clr_i | input | 1 | One-cycle strobe: drop send residue |
| rx_clr_i | input | 1 | One-cycle strobe: drop receive residue |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word ready |
| out_data_o | output | 16 | Output word |
| tx_resid_o | output | 1 | A send byte is parked |
| rx_resid_o | output | 1 | A receive byte is parked |

## Verification
A wrong parked byte, or a residue flag stuck in the wrong state, stays hidden until the next block in the same direction starts. At that point it shows up as a wrong low half in the first word, or as a missing or extra word, one cycle after that first byte. A wrongly set or cleared flag is visible on its own port one cycle after the event that should have changed it. The bench therefore keeps a behavioural model of parked bytes per direction and compares flags, ready, valid and data on every cycle. It also runs long random mixes of direction, mode, block ends, clears and back-pressure.

// File: rtl/bpp_pkg.sv
`timescale 1ns/1ps
package bpp_pkg;
    localparam int NUM_LANES = 2;
    localparam int LANE_SEND = 0;
    localparam int LANE_RECV = 1;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } bpp_dir_e;
endpackage

// File: rtl/bpp_lane.sv
`timescale 1ns/1ps
module bpp_lane #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wide_i,
    input  logic              last_i,
    input  logic              kill_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              avail_o,
    output logic [BYTE_W-1:0] hold_o,
    output logic              flag_o
);
    typedef struct packed {
        logic              pend;
        logic              flag;
        logic [BYTE_W-1:0] hold;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     avail;

    always_comb begin
        st_d  = st_q;
        avail = st_q.pend | (st_q.flag & ~kill_i);
        if (kill_i) begin
            st_d.flag = 1'b0;
        end
        if (sel_i) begin
            if (!wide_i) begin
                st_d.pend = 1'b0;
            end else if (avail) begin
                st_d.pend = 1'b0;
                st_d.flag = 1'b0;
            end else begin
                st_d.hold = byte_i;
                st_d.pend = ~last_i;
                st_d.flag = last_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail_o = avail;
    assign hold_o  = st_q.hold;
    assign flag_o  = st_q.flag;

    // R3 / R5: an unpaired closing wide byte raises the flag
    assert_odd_end_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && wide_i && last_i && !avail_o |=> flag_o);

    // R3 / R5: the flag rises only for such a byte
    assert_flag_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(sel_i && wide_i && last_i));

    // R6: a drop request always lowers the flag unless a new residue is parked
    assert_kill_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i && !(sel_i && wide_i && last_i) |=> !flag_o);
endmodule

// File: rtl/bpp_out_stage.sv
`timescale 1ns/1ps
module bpp_out_stage #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              space_o
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.word  = word_i;
        end else if (ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;
    assign space_o = ~st_q.valid | ready_i;

    // R9: a stalled word holds still
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(word_o));

    // R9: no word is loaded over one that is still stalled
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !(valid_o && !ready_i));
endmodule

// File: rtl/byte_pair_packer.sv
`timescale 1ns/1ps
module byte_pair_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    output logic                in_ready_o,
    input  logic [BYTE_W-1:0]   in_data_i,
    input  logic                in_last_i,
    input  logic                in_dir_i,
    input  logic                in_wide_i,
    input  logic                tx_clr_i,
    input  logic                rx_clr_i,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic [2*BYTE_W-1:0] out_data_o,
    output logic                tx_resid_o,
    output logic                rx_resid_o
);
    import bpp_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;

    logic                 accept;
    logic                 space;
    logic                 load;
    logic [WORD_W-1:0]    word;
    logic                 cur_avail;
    logic [BYTE_W-1:0]    cur_hold;
    bpp_dir_e             dir;
    logic [NUM_LANES-1:0] lane_sel;
    logic [NUM_LANES-1:0] lane_kill;
    logic [NUM_LANES-1:0] lane_avail;
    logic [NUM_LANES-1:0] lane_flag;
    logic [BYTE_W-1:0]    lane_hold [NUM_LANES];

    assign dir    = bpp_dir_e'(in_dir_i);
    assign accept = in_valid_i & space;

    always_comb begin
        lane_sel            = '0;
        lane_sel[LANE_SEND] = accept & (dir == DIR_SEND);
        lane_sel[LANE_RECV] = accept & (dir == DIR_RECV);
        lane_kill            = '0;
        lane_kill[LANE_SEND] = tx_clr_i | (accept & ((dir == DIR_RECV) | ~in_wide_i));
        lane_kill[LANE_RECV] = rx_clr_i;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        bpp_lane #(.BYTE_W(BYTE_W)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (lane_sel[g]),
            .wide_i  (in_wide_i),
            .last_i  (in_last_i),
            .kill_i  (lane_kill[g]),
            .byte_i  (in_data_i),
            .avail_o (lane_avail[g]),
            .hold_o  (lane_hold[g]),
            .flag_o  (lane_flag[g])
        );
    end

    always_comb begin
        if (dir == DIR_RECV) begin
            cur_avail = lane_avail[LANE_RECV];
            cur_hold  = lane_hold[LANE_RECV];
        end else begin
            cur_avail = lane_avail[LANE_SEND];
            cur_hold  = lane_hold[LANE_SEND];
        end
        load = accept & (~in_wide_i | cur_avail);
        if (in_wide_i) begin
            word = {in_data_i, cur_hold};
        end else begin
            word = {{BYTE_W{1'b0}}, in_data_i};
        end
    end

    bpp_out_stage #(.WORD_W(WORD_W)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (word),
        .ready_i (out_ready_i),
        .valid_o (out_valid_o),
        .word_o  (out_data_o),
        .space_o (space)
    );

    assign in_ready_o = space;
    assign tx_resid_o = lane_flag[LANE_SEND];
    assign rx_resid_o = lane_flag[LANE_RECV];

    // R1: reset leaves everything empty
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid_o && !tx_resid_o && !rx_resid_o);

    // R7: a receive byte drops the send residue
    assert_recv_drops_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o && in_dir_i |=> !tx_resid_o);

    // R8: narrow byte gives a zero-extended word and drops the send residue
    assert_narrow_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o && !in_wide_i |=>
            out_valid_o && out_data_o[WORD_W-1:BYTE_W] == '0 && !tx_resid_o);

    // R4: a parked send byte becomes the low half of the next send word
    assert_send_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o && !in_dir_i && in_wide_i && tx_resid_o && !tx_clr_i |=>
            out_valid_o && out_data_o == {$past(in_data_i), $past(lane_hold[LANE_SEND])});

    // R9: ready drops only while a word is stalled
    assert_ready_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o == !(out_valid_o && !out_ready_i));
endmodule

// File: tb/byte_pair_packer_tb_top.sv
`timescale 1ns/1ps
module byte_pair_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_dir = 1'b0;
    logic        in_wide = 1'b1;
    logic        tx_clr = 1'b0;
    logic        rx_clr = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        tx_resid;
    logic        rx_resid;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_ov;
    bit [15:0] m_od;
    bit       m_flag [2];
    bit       m_pend [2];
    bit [7:0] m_hold [2];
    logic [15:0] got_q [$];

    always #2 clk = ~clk;

    byte_pair_packer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .in_data_i   (in_data),
        .in_last_i   (in_last),
        .in_dir_i    (in_dir),
        .in_wide_i   (in_wide),
        .tx_clr_i    (tx_clr),
        .rx_clr_i    (rx_clr),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .tx_resid_o  (tx_resid),
        .rx_resid_o  (rx_resid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural model: one step per clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ov = 0; m_od = '0;
            for (int i = 0; i < 2; i++) begin
                m_flag[i] = 0; m_pend[i] = 0; m_hold[i] = '0;
            end
        end else begin
            bit acc, emit;
            bit [15:0] w;
            int d;
            acc  = in_valid && (!m_ov || out_ready);
            emit = 0;
            w    = '0;
            d    = in_dir ? 1 : 0;
            if (tx_clr) m_flag[0] = 0;
            if (rx_clr) m_flag[1] = 0;
            if (acc) begin
                if (d == 1) m_flag[0] = 0;
                if (!in_wide) begin
                    m_flag[0] = 0;
                    m_pend[d] = 0;
                    emit = 1;
                    w = {8'h00, in_data};
                end else if (m_pend[d] || m_flag[d]) begin
                    emit = 1;
                    w = {in_data, m_hold[d]};
                    m_pend[d] = 0;
                    m_flag[d] = 0;
                end else begin
                    m_hold[d] = in_data;
                    m_pend[d] = !in_last;
                    m_flag[d] = in_last;
                end
            end
            if (emit) begin
                m_ov = 1; m_od = w;
            end else if (out_ready) begin
                m_ov = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(out_valid == m_ov, cur_req, "out_valid", 32'(out_valid), 32'(m_ov));
            if (m_ov) check(out_data == m_od, cur_req, "out_data", 32'(out_data), 32'(m_od));
            check(in_ready == (!m_ov || out_ready), "R9", "in_ready",
                  32'(in_ready), 32'(!m_ov || out_ready));
            check(tx_resid == m_flag[0], cur_req, "tx_resid", 32'(tx_resid), 32'(m_flag[0]));
            check(rx_resid == m_flag[1], cur_req, "rx_resid", 32'(rx_resid), 32'(m_flag[1]));
            if (out_valid && out_ready) got_q.push_back(out_data);
        end
    end

    task automatic put(input bit d, input bit [7:0] b, input bit l, input bit w, input bit c);
        bit ok;
        @(posedge clk); #1;
        in_valid = 1; in_dir = d; in_data = b; in_last = l; in_wide = w; tx_clr = c;
        forever begin
            #2 ok = in_ready;
            @(posedge clk);
            if (ok) break;
            #1;
        end
        #1 in_valid = 0; tx_clr = 0;
    endtask

    task automatic pulse(input bit t, input bit r);
        @(posedge clk); #1 tx_clr = t; rx_clr = r;
        @(posedge clk); #1 tx_clr = 0; rx_clr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_word(input bit [15:0] exp, input string req);
        if (got_q.size() == 0) begin
            check(0, req, "word missing", 32'h0, 32'(exp));
        end else begin
            logic [15:0] g;
            g = got_q.pop_front();
            check(g == exp, req, "word", 32'(g), 32'(exp));
        end
    endtask

    task automatic expect_flags(input bit t, input bit r, input string req);
        @(negedge clk);
        check(tx_resid == t, req, "tx_resid", 32'(tx_resid), 32'(t));
        check(rx_resid == r, req, "rx_resid", 32'(rx_resid), 32'(r));
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0 && tx_resid == 0 && rx_resid == 0, "R1", "reset outputs",
              {29'h0, out_valid, tx_resid, rx_resid}, 32'h0);
        check(in_ready == 1, "R1", "reset in_ready", 32'(in_ready), 32'h1);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 0 && tx_resid == 0 && rx_resid == 0 && in_ready == 1, "R1",
              "after release", {28'h0, out_valid, tx_resid, rx_resid, in_ready}, 32'h1);

        // R2: even wide send block
        cur_req = "R2"; got_q.delete();
        put(0, 8'h11, 0, 1, 0); put(0, 8'h22, 0, 1, 0);
        put(0, 8'h33, 0, 1, 0); put(0, 8'h44, 1, 1, 0);
        idle(2);
        expect_word(16'h2211, "R2"); expect_word(16'h4433, "R2");
        expect_flags(0, 0, "R2");

        // R3 / R4: odd send block chains into next send block
        cur_req = "R3";
        put(0, 8'hA1, 0, 1, 0); put(0, 8'hA2, 0, 1, 0); put(0, 8'hA3, 1, 1, 0);
        idle(2);
        expect_word(16'hA2A1, "R3");
        check(got_q.size() == 0, "R3", "extra word", 32'(got_q.size()), 32'h0);
        expect_flags(1, 0, "R3");
        cur_req = "R4";
        put(0, 8'hB1, 0, 1, 0); put(0, 8'hB2, 1, 1, 0);
        idle(2);
        expect_word(16'hB1A3, "R4");
        expect_flags(1, 0, "R4");

        // R5 / R7: receive residue, separate from send
        cur_req = "R5";
        put(1, 8'hC1, 1, 1, 0);
        idle(2);
        check(got_q.size() == 0, "R5", "no word for odd rx", 32'(got_q.size()), 32'h0);
        expect_flags(0, 1, "R7");
        put(1, 8'hC2, 0, 1, 0); put(1, 8'hC3, 1, 1, 0);
        idle(2);
        expect_word(16'hC2C1, "R5");
        expect_flags(0, 1, "R5");

        // R6: clear strobes
        cur_req = "R6";
        pulse(0, 1);
        expect_flags(0, 0, "R6");
        put(0, 8'hD1, 1, 1, 0);
        pulse(1, 0);
        expect_flags(0, 0, "R6");
        put(0, 8'hD2, 0, 1, 0); put(0, 8'hD3, 1, 1, 0);
        idle(2);
        expect_word(16'hD3D2, "R6");
        put(0, 8'hE1, 1, 1, 0);
        put(0, 8'hE2, 0, 1, 1); put(0, 8'hE3, 1, 1, 0);
        idle(2);
        expect_word(16'hE3E2, "R6");
        expect_flags(0, 0, "R6");

        // R8: narrow transfer
        cur_req = "R8";
        put(0, 8'hF1, 1, 1, 0);
        put(1, 8'h71, 1, 1, 0);
        put(0, 8'hF2, 1, 1, 0);
        put(0, 8'h5A, 1, 0, 0);
        idle(2);
        expect_word(16'h005A, "R8");
        expect_flags(0, 1, "R8");
        put(1, 8'h72, 0, 1, 0);
        idle(2);
        expect_word(16'h7271, "R5");

        // R9: back-pressure
        cur_req = "R9";
        @(posedge clk); #1 out_ready = 0;
        put(0, 8'h61, 0, 1, 0); put(0, 8'h62, 0, 1, 0);
        fork
            put(0, 8'h63, 0, 1, 0);
            begin
                repeat (5) begin
                    @(negedge clk);
                    check(in_ready == 0 && out_valid == 1 && out_data == 16'h6261, "R9",
                          "stall", {15'h0, in_ready, out_data}, 32'h00006261);
                end
                @(posedge clk); #1 out_ready = 1;
            end
        join
        put(0, 8'h64, 1, 1, 0);
        idle(2);
        expect_word(16'h6261, "R9"); expect_word(16'h6463, "R9");

        // random mix, checked by the cycle model
        cur_req = "R2";
        for (int i = 0; i < 1500; i++) begin
            @(posedge clk); #1;
            in_valid  = ($urandom % 4) != 0;
            in_dir    = ($urandom % 3) == 0;
            in_wide   = ($urandom % 6) != 0;
            in_last   = ($urandom % 3) == 0;
            in_data   = 8'($urandom);
            tx_clr    = ($urandom % 20) == 0;
            rx_clr    = ($urandom % 20) == 0;
            out_ready = ($urandom % 4) != 0;
        end
        @(posedge clk); #1;
        in_valid = 0; tx_clr = 0; rx_clr = 0; out_ready = 1;
        idle(4);

        report();
        $finish;
    end
endmodule